// File: doc/BRIEF.md
# Driver Fault Protection Supervisor

This block supervises the protection state of a driver with two coils, X and Y, each driven by its own H-bridge. It takes in the digital outputs of the thermal comparators, one over-current comparator per bridge transistor, and one full-duty indicator per coil from the PWM regulators. From these it keeps sticky status flags and drives an enable line per bridge. A low enable line puts that bridge's transistors in high impedance.

Software sees the flags through the serial status path, which sits outside this block. The serial logic gives the block a one-cycle strobe on every status read. It also gives explicit clear strobes for the over-current flags and the open-coil flags. After reset the bridges stay off until the controller pulses the arm input.

The open-coil timer counts clock cycles. Its window length is `CLK_PER_MS * OPEN_MS` cycles, which is 200 ms by default.

Top module: `fps_supervisor`

## Requirements
- R1: The warning flag `tw_o` is set one cycle after `temp_warn_i` is sampled high. It is cleared by a `stat_rd_i` strobe in a cycle where `temp_warn_i` is low, and otherwise it holds.
- R2: The shutdown flag `tsd_o` is set one cycle after `temp_shut_i` is sampled high. While it is set, both `en_x_o` and `en_y_o` are low.
- R3: `tsd_o` is cleared only by a `stat_rd_i` strobe in a cycle where both `temp_warn_i` and `temp_shut_i` are low. A read while the warning input is high leaves the flag set.
- R4: Bit i of `ovc_x_o` / `ovc_y_o` is set one cycle after bit i of `ovc_x_i` / `ovc_y_i` is sampled high. Bit i belongs to transistor i of that bridge.
- R5: Over-current flags stay set until `clr_ovc_i` is strobed. While any flag on either bridge is set, both enables are low.
- R6: A clear strobe has no effect on a flag whose fault input is high in the same cycle. This applies to both `clr_ovc_i` and `clr_open_i`.
- R7: When `full_x_i` (or `full_y_i`) is sampled high on `LIMIT+1` consecutive cycles, where `LIMIT = CLK_PER_MS*OPEN_MS`, `open_x_o` (or `open_y_o`) is set on the last of those edges. Only that coil's enable then goes low.
- R8: A cycle with the full-duty input low restarts that coil's count from zero.
- R9: `clr_open_i` clears both open-coil flags.
- R10: After reset every flag and enable is 0. An enable goes high one cycle after `arm_i` is first sampled high, and only if that bridge has no shutdown, over-current or open-coil flag. Enables always change on the same edge as the flags that gate them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_warn_i | input | 1 | Junction above warning threshold |
| temp_shut_i | input | 1 | Junction above shutdown threshold |
| ovc_x_i | input | NSW | Over-current comparators, X bridge transistors |
| ovc_y_i | input | NSW | Over-current comparators, Y bridge transistors |
| full_x_i | input | 1 | X coil PWM at 100 % duty |
| full_y_i | input | 1 | Y coil PWM at 100 % duty |
| stat_rd_i | input | 1 | Any status read strobe |
| clr_ovc_i | input | 1 | Clear over-current flags |
| clr_open_i | input | 1 | Clear open-coil flags |
| arm_i | input | 1 | Enable the drivers after reset |
| tw_o | output | 1 | Thermal warning flag |
| tsd_o | output | 1 | Thermal shutdown flag |
| ovc_x_o | output | NSW | Latched over-current flags, X bridge |
| ovc_y_o | output | NSW | Latched over-current flags, Y bridge |
| open_x_o | output | 1 | Open-coil flag, X coil |
| open_y_o | output | 1 | Open-coil flag, Y coil |
| en_x_o | output | 1 | X bridge enable (0 = high impedance) |
| en_y_o | output | 1 | Y bridge enable (0 = high impedance) |

## Verification
The bench builds the block with `CLK_PER_MS=4` and `OPEN_MS=5`, which gives a 20-cycle open-coil window. This short window lets the bench reach the exact firing edge, a restart one cycle before firing, and both coils firing separately within a few hundred cycles. `NSW` stays at 4, so every transistor bit on both bridges can be tripped and cleared one at a time. The bench also drives clear strobes in the same cycle as an active fault on both flag kinds.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef struct packed {
    logic tw;
    logic tsd;
  } therm_flags_t;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/fps_thermal.sv
module fps_thermal
  import fps_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         warn_i,
  input  logic         shut_i,
  input  logic         rd_i,
  output therm_flags_t nxt_o,
  output therm_flags_t q_o
);
  therm_flags_t q;

  always_comb begin
    nxt_o = q;
    if (warn_i)     nxt_o.tw = 1'b1;
    else if (rd_i)  nxt_o.tw = 1'b0;
    if (shut_i)                nxt_o.tsd = 1'b1;
    else if (rd_i && !warn_i)  nxt_o.tsd = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt_o;
  end

  assign q_o = q;
endmodule

// File: rtl/fps_ovc_latch.sv
module fps_ovc_latch #(
  parameter int unsigned NSW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NSW-1:0] trip_i,
  input  logic           clr_i,
  output logic [NSW-1:0] nxt_o,
  output logic [NSW-1:0] q_o
);
  for (genvar i = 0; i < NSW; i++) begin : g_bit
    logic q;
    assign nxt_o[i] = trip_i[i] | (q & ~clr_i);
    always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= nxt_o[i];
    end
    assign q_o[i] = q;
  end
endmodule

// File: rtl/fps_open_timer.sv
module fps_open_timer
  import fps_pkg::*;
#(
  parameter int unsigned LIMIT = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic full_i,
  input  logic clr_i,
  output logic nxt_o,
  output logic q_o
);
  localparam int unsigned CW = cnt_width(LIMIT);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;
  logic          q;
  logic          fire;

  assign fire  = full_i && (cnt == LIM);
  assign nxt_o = fire | (q & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      q   <= 1'b0;
    end else begin
      if (!full_i)        cnt <= '0;
      else if (cnt != LIM) cnt <= cnt + 1'b1;
      q <= nxt_o;
    end
  end

  assign q_o = q;
endmodule

// File: rtl/fps_supervisor.sv
module fps_supervisor
  import fps_pkg::*;
#(
  parameter int unsigned NSW        = 4,
  parameter int unsigned CLK_PER_MS = 100000,
  parameter int unsigned OPEN_MS    = 200
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           temp_warn_i,
  input  logic           temp_shut_i,
  input  logic [NSW-1:0] ovc_x_i,
  input  logic [NSW-1:0] ovc_y_i,
  input  logic           full_x_i,
  input  logic           full_y_i,
  input  logic           stat_rd_i,
  input  logic           clr_ovc_i,
  input  logic           clr_open_i,
  input  logic           arm_i,
  output logic           tw_o,
  output logic           tsd_o,
  output logic [NSW-1:0] ovc_x_o,
  output logic [NSW-1:0] ovc_y_o,
  output logic           open_x_o,
  output logic           open_y_o,
  output logic           en_x_o,
  output logic           en_y_o
);
  localparam int unsigned LIMIT = CLK_PER_MS * OPEN_MS;

  therm_flags_t th_nxt, th_q;
  logic [NSW-1:0] ox_nxt, oy_nxt;
  logic [1:0] full_in, open_nxt, open_q;
  logic armed, armed_nxt;
  logic any_ovc_nxt;

  fps_thermal u_therm (
    .clk(clk), .rst(rst), .warn_i(temp_warn_i), .shut_i(temp_shut_i),
    .rd_i(stat_rd_i), .nxt_o(th_nxt), .q_o(th_q)
  );

  fps_ovc_latch #(.NSW(NSW)) u_ovc_x (
    .clk(clk), .rst(rst), .trip_i(ovc_x_i), .clr_i(clr_ovc_i),
    .nxt_o(ox_nxt), .q_o(ovc_x_o)
  );

  fps_ovc_latch #(.NSW(NSW)) u_ovc_y (
    .clk(clk), .rst(rst), .trip_i(ovc_y_i), .clr_i(clr_ovc_i),
    .nxt_o(oy_nxt), .q_o(ovc_y_o)
  );

  assign full_in = {full_y_i, full_x_i};

  for (genvar c = 0; c < 2; c++) begin : g_coil
    fps_open_timer #(.LIMIT(LIMIT)) u_timer (
      .clk(clk), .rst(rst), .full_i(full_in[c]), .clr_i(clr_open_i),
      .nxt_o(open_nxt[c]), .q_o(open_q[c])
    );
  end

  assign armed_nxt   = armed | arm_i;
  assign any_ovc_nxt = (|ox_nxt) | (|oy_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      en_x_o <= 1'b0;
      en_y_o <= 1'b0;
    end else begin
      armed  <= armed_nxt;
      en_x_o <= armed_nxt & ~th_nxt.tsd & ~any_ovc_nxt & ~open_nxt[0];
      en_y_o <= armed_nxt & ~th_nxt.tsd & ~any_ovc_nxt & ~open_nxt[1];
    end
  end

  assign tw_o     = th_q.tw;
  assign tsd_o    = th_q.tsd;
  assign open_x_o = open_q[0];
  assign open_y_o = open_q[1];
endmodule

// File: rtl/fps_supervisor_chk.sv
module fps_supervisor_chk #(
  parameter int unsigned NSW = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           temp_warn_i,
  input logic           temp_shut_i,
  input logic [NSW-1:0] ovc_x_i,
  input logic           stat_rd_i,
  input logic           clr_ovc_i,
  input logic           tw_o,
  input logic           tsd_o,
  input logic [NSW-1:0] ovc_x_o,
  input logic [NSW-1:0] ovc_y_o,
  input logic           open_x_o,
  input logic           open_y_o,
  input logic           en_x_o,
  input logic           en_y_o
);
  p_warn_set_r1: assert property (@(posedge clk) disable iff (rst)
    temp_warn_i |=> tw_o);

  p_shut_hiz_r2: assert property (@(posedge clk) disable iff (rst)
    tsd_o |-> (!en_x_o && !en_y_o));

  p_shut_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (tsd_o && temp_warn_i) |=> tsd_o);

  p_shut_noread_r3: assert property (@(posedge clk) disable iff (rst)
    (tsd_o && !stat_rd_i) |=> tsd_o);

  p_ovc_set_r4: assert property (@(posedge clk) disable iff (rst)
    (ovc_x_i != '0) |=> ((ovc_x_o & $past(ovc_x_i)) == $past(ovc_x_i)));

  p_ovc_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !clr_ovc_i |=> ((ovc_x_o & $past(ovc_x_o)) == $past(ovc_x_o)));

  p_ovc_off_r5: assert property (@(posedge clk) disable iff (rst)
    ((ovc_x_o != '0) || (ovc_y_o != '0)) |-> (!en_x_o && !en_y_o));

  p_open_off_r7: assert property (@(posedge clk) disable iff (rst)
    (open_x_o |-> !en_x_o) and (open_y_o |-> !en_y_o));
endmodule

bind fps_supervisor fps_supervisor_chk #(.NSW(NSW)) u_chk (
  .clk(clk), .rst(rst), .temp_warn_i(temp_warn_i), .temp_shut_i(temp_shut_i),
  .ovc_x_i(ovc_x_i), .stat_rd_i(stat_rd_i), .clr_ovc_i(clr_ovc_i),
  .tw_o(tw_o), .tsd_o(tsd_o), .ovc_x_o(ovc_x_o), .ovc_y_o(ovc_y_o),
  .open_x_o(open_x_o), .open_y_o(open_y_o), .en_x_o(en_x_o), .en_y_o(en_y_o)
);

// File: tb/fps_supervisor_test.sv
`timescale 1ns/1ps
module fps_supervisor_test;
  localparam int NSW = 4;
  localparam int CPM = 4;
  localparam int OMS = 5;
  localparam int LIM = CPM * OMS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic warn = 0, shut = 0, fx = 0, fy = 0, rd = 0, cov = 0, cop = 0, arm = 0;
  logic [NSW-1:0] ix = '0, iy = '0;
  logic tw, tsd, opx, opy, enx, eny;
  logic [NSW-1:0] ox, oy;

  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  fps_supervisor #(.NSW(NSW), .CLK_PER_MS(CPM), .OPEN_MS(OMS)) uut (
    .clk(clk), .rst(rst), .temp_warn_i(warn), .temp_shut_i(shut),
    .ovc_x_i(ix), .ovc_y_i(iy), .full_x_i(fx), .full_y_i(fy),
    .stat_rd_i(rd), .clr_ovc_i(cov), .clr_open_i(cop), .arm_i(arm),
    .tw_o(tw), .tsd_o(tsd), .ovc_x_o(ox), .ovc_y_o(oy),
    .open_x_o(opx), .open_y_o(opy), .en_x_o(enx), .en_y_o(eny)
  );

  // behavioural reference
  logic m_tw = 0, m_tsd = 0, m_opx = 0, m_opy = 0, m_arm = 0, m_enx = 0, m_eny = 0;
  logic [NSW-1:0] m_ox = '0, m_oy = '0;
  int run_x = 0, run_y = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_tw = 0; m_tsd = 0; m_opx = 0; m_opy = 0; m_arm = 0;
      m_ox = '0; m_oy = '0; run_x = 0; run_y = 0; m_enx = 0; m_eny = 0;
    end else begin
      if (warn) m_tw = 1; else if (rd) m_tw = 0;
      if (shut) m_tsd = 1; else if (rd && !warn) m_tsd = 0;
      for (int i = 0; i < NSW; i++) begin
        if (ix[i]) m_ox[i] = 1; else if (cov) m_ox[i] = 0;
        if (iy[i]) m_oy[i] = 1; else if (cov) m_oy[i] = 0;
      end
      run_x = fx ? run_x + 1 : 0;
      run_y = fy ? run_y + 1 : 0;
      if (run_x > LIM) m_opx = 1; else if (cop) m_opx = 0;
      if (run_y > LIM) m_opy = 1; else if (cop) m_opy = 0;
      if (arm) m_arm = 1;
      m_enx = m_arm && !m_tsd && (m_ox == 0) && (m_oy == 0) && !m_opx;
      m_eny = m_arm && !m_tsd && (m_ox == 0) && (m_oy == 0) && !m_opy;
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R1 tw", 32'(tw), 32'(m_tw));
    chk("R3 tsd", 32'(tsd), 32'(m_tsd));
    chk("R4 ovc_x", 32'(ox), 32'(m_ox));
    chk("R4 ovc_y", 32'(oy), 32'(m_oy));
    chk("R7 open_x", 32'(opx), 32'(m_opx));
    chk("R7 open_y", 32'(opy), 32'(m_opy));
    chk("R10 en_x", 32'(enx), 32'(m_enx));
    chk("R10 en_y", 32'(eny), 32'(m_eny));
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare();
      rd = 0; cov = 0; cop = 0; arm = 0;
    end
  endtask

  initial begin
    step(3);
    rst = 0;
    step(2);
    chk("R10 reset en_x", 32'(enx), 0);
    chk("R10 reset flags", 32'({tw, tsd, ox, oy, opx, opy}), 0);
    arm = 1; step(1);
    chk("R10 armed en", 32'({enx, eny}), 32'h3);

    // thermal
    warn = 1; step(2);
    chk("R1 warn set", 32'(tw), 1);
    shut = 1; step(1);
    chk("R2 shut set", 32'(tsd), 1);
    chk("R2 hiz", 32'({enx, eny}), 0);
    shut = 0; rd = 1; step(1);
    chk("R3 read while warm keeps", 32'(tsd), 1);
    chk("R1 read while warm keeps", 32'(tw), 1);
    warn = 0; step(2);
    chk("R3 no read keeps", 32'(tsd), 1);
    rd = 1; step(1);
    chk("R3 read cool clears", 32'(tsd), 0);
    chk("R1 read cool clears", 32'(tw), 0);
    chk("R2 enables back", 32'({enx, eny}), 32'h3);

    // over-current, each transistor
    for (int i = 0; i < NSW; i++) begin
      ix = NSW'(1 << i); step(1); ix = '0; step(2);
      chk("R4 x bit", 32'(ox), 32'(1 << i));
      chk("R5 all off", 32'({enx, eny}), 0);
      cov = 1; step(1);
      chk("R5 cleared", 32'(ox), 0);
      iy = NSW'(1 << i); step(1); iy = '0;
      chk("R4 y bit", 32'(oy), 32'(1 << i));
      cov = 1; step(1);
    end
    ix = 4'b0011; step(1);
    ix = 4'b0001; cov = 1; step(1);
    chk("R6 clear vs active ovc", 32'(ox), 32'h1);
    ix = '0; cov = 1; step(1);
    chk("R5 clear", 32'(ox), 0);

    // open coil
    fx = 1; step(LIM);
    chk("R7 not yet", 32'(opx), 0);
    step(1);
    chk("R7 fired", 32'(opx), 1);
    chk("R7 x off", 32'(enx), 0);
    chk("R7 y unaffected", 32'(eny), 1);
    cop = 1; step(1);
    chk("R6 clear vs full", 32'(opx), 1);
    fx = 0; cop = 1; step(1);
    chk("R9 cleared", 32'(opx), 0);
    fy = 1; step(LIM); fy = 0; step(1); fy = 1; step(LIM);
    chk("R8 restart", 32'(opy), 0);
    step(1);
    chk("R8 fires after full window", 32'(opy), 1);
    fy = 0; cop = 1; step(2);
    chk("R9 y cleared", 32'(opy), 0);

    // reset mid-fault then rearm
    ix = 4'b1000; step(1); ix = '0;
    rst = 1; step(2); rst = 0; step(2);
    chk("R10 reset clears", 32'({ox, enx, eny}), 0);
    arm = 1; step(2);
    chk("R10 rearm", 32'({enx, eny}), 32'h3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule